// File: doc/BRIEF.md
# Row/Column Decoded Static Memory Array

This block is a small synchronous static memory. Its storage cells sit in a matrix of rows and columns. An address splits into a row field and a column field. Each field drives its own one-hot decoder, and a cell responds only where its row line and its column line are both high. Chip select gates both decoders. With chip select low, no line in the matrix rises, and no cell can be written or read.

A direction input picks the operation for a selected cell. When it is 1, the cell captures the data input at the clock edge. When it is 0, the cell's stored word goes to the registered output one clock later, together with a valid flag. Each address holds a word of parallel bit planes, and all the planes share one pair of decoders. With the default parameters the array has 4 rows by 4 columns of 4-bit words. Setting both field widths to 1 gives a 2x2 array.

Top module: `coord_sram`

## Requirements
- R1: With the default parameters there are 16 addressable words, each `WIDTH` bits wide. Address bits [3:2] choose the row and address bits [1:0] choose the column, so the word index is row*4+column.
- R2: While `cs` is 1, `row_lines` has exactly one bit set, at the position given by the row field. `col_lines` has exactly one bit set, at the position given by the column field. Exactly one cell is selected.
- R3: While `cs` is 0, every bit of `row_lines` and `col_lines` is 0. No cell changes, even when `wr` is 1.
- R4: When `cs`=1 and `wr`=1 at a rising clock edge, the addressed word takes the value of `din`. Every other word keeps its value.
- R5: When `cs`=1 and `wr`=0 at a rising clock edge, `rdata` shows the addressed word as it was before that edge, and `rvalid` is 1, from that edge until the next one.
- R6: After an edge at which no read took place (a write, or `cs`=0), `rdata` is all zeros and `rvalid` is 0.
- R7: While `rst_n` is low, every stored word is cleared to 0 and `rdata` and `rvalid` are 0.
- R8: Each bit plane stores its bit independently, so any mix of ones and zeros written to a word reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, gates both decoders |
| wr | input | 1 | 1 = store din, 0 = read |
| addr | input | ROW_BITS+COL_BITS | Row field (upper bits) and column field (lower bits) |
| din | input | WIDTH | Write data |
| row_lines | output | 2**ROW_BITS | One-hot row select lines |
| col_lines | output | 2**COL_BITS | One-hot column select lines |
| rdata | output | WIDTH | Registered read data, zero when not reading |
| rvalid | output | 1 | Read data valid |

## Verification
A wrong decoder line shows up on `row_lines` or `col_lines` in the same cycle the address is applied. A selection fault instead shows up as a corrupted word: the next read of either the intended address or the wrongly hit address returns the fault one clock after that read is issued. The stimulus is mostly random and keeps a model of every word, so each read compares against the full write history. Because the addresses are revisited often, a write that leaks into a neighbouring cell or bit plane is exposed within a few dozen cycles.

// File: rtl/coord_sram.sv
module coord_sram #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int WIDTH    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs,
  input  logic                         wr,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [WIDTH-1:0]             din,
  output logic [(1<<ROW_BITS)-1:0]     row_lines,
  output logic [(1<<COL_BITS)-1:0]     col_lines,
  output logic [WIDTH-1:0]             rdata,
  output logic                         rvalid
);
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int COLS   = 1 << COL_BITS;
  localparam int CELLS  = ROWS * COLS;
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  logic [ROW_BITS-1:0] row_field;
  logic [COL_BITS-1:0] col_field;
  logic [CELLS-1:0]    cell_sel;
  logic [WIDTH-1:0]    cell_out [CELLS];
  logic [WIDTH-1:0]    rd_word;
  logic                do_read;

  assign row_field = addr[ADDR_W-1:COL_BITS];
  assign col_field = addr[COL_BITS-1:0];
  assign do_read   = cs & ~wr;

  // row and column decoders, both gated by chip select
  always_comb begin
    row_lines = '0;
    col_lines = '0;
    if (cs) begin
      row_lines[row_field] = 1'b1;
      col_lines[col_field] = 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [WIDTH-1:0] q;
      assign cell_sel[r*COLS+c] = row_lines[r] & col_lines[c];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (cell_sel[r*COLS+c] && wr)
          q <= din;
      end
      assign cell_out[r*COLS+c] = (cell_sel[r*COLS+c] && !wr) ? q : '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < CELLS; i++)
      rd_word = rd_word | cell_out[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= do_read ? rd_word : '0;
      rvalid <= do_read;
    end
  end

  a_r2_lines_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> ($countones(row_lines) == 1 && $countones(col_lines) == 1));

  a_r2_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> $countones(cell_sel) == 1);

  a_r3_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (row_lines == '0 && col_lines == '0 && cell_sel == '0));

  a_r5_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !wr) |=> rvalid);

  a_r6_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !wr) |=> (!rvalid && rdata == '0));

endmodule

// File: tb/tb_coord_sram.sv
`timescale 1ns/1ps
module tb_coord_sram;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0;
  logic         wr = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] din = '0;
  logic [3:0]   row_lines, col_lines;
  logic [W-1:0] rdata;
  logic         rvalid;

  logic [W-1:0] model [16];
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  coord_sram #(.ROW_BITS(2), .COL_BITS(2), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .din(din),
    .row_lines(row_lines), .col_lines(col_lines), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [3:0] exp_row(logic c, logic [3:0] a);
    return c ? (4'b0001 << a[3:2]) : 4'b0000;
  endfunction

  function automatic logic [3:0] exp_col(logic c, logic [3:0] a);
    return c ? (4'b0001 << a[1:0]) : 4'b0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic op(logic c, logic w, logic [3:0] a, logic [W-1:0] d, string req);
    logic [W-1:0] e_data;
    logic         e_valid;
    @(negedge clk);
    cs = c; wr = w; addr = a; din = d;
    #1;
    check(c ? "R2 row" : "R3 row", row_lines, exp_row(c, a));
    check(c ? "R2 col" : "R3 col", col_lines, exp_col(c, a));
    e_valid = c && !w;
    e_data  = e_valid ? model[a] : '0;
    @(posedge clk);
    #1;
    if (c && w) model[a] = d;
    check({req, " data"}, rdata, e_data);
    check(e_valid ? "R5 valid" : "R6 valid", rvalid, e_valid);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c0de);
    for (int i = 0; i < 16; i++) model[i] = '0;
    #9;
    check("R7 rvalid", rvalid, 0);
    check("R7 rdata", rdata, 0);
    rst_n = 1'b1;
    // R7: all words cleared
    for (int i = 0; i < 16; i++) op(1, 0, 4'(i), '0, "R7");
    // R1/R4: distinct pattern per word, then read all back
    for (int i = 0; i < 16; i++) op(1, 1, 4'(i), 4'(i ^ 4'ha), "R4");
    for (int i = 0; i < 16; i++) op(1, 0, 4'(i), '0, "R1");
    // R3: write attempt while deselected must not land
    op(0, 1, 4'd5, 4'h0, "R3");
    op(0, 0, 4'd9, 4'h0, "R3");
    op(1, 0, 4'd5, '0, "R3");
    // R8: walking planes at one corner and opposite corner
    op(1, 1, 4'd0, 4'b0101, "R8");
    op(1, 1, 4'd15, 4'b1010, "R8");
    op(1, 0, 4'd0, '0, "R8");
    op(1, 0, 4'd15, '0, "R8");
    // R5: read right after a write to same address sees new word
    op(1, 1, 4'd6, 4'hf, "R5");
    op(1, 0, 4'd6, '0, "R5");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0] | r[1], r[2], r[7:4], r[11:8], "R4/R5 random");
    end
    for (int i = 0; i < 16; i++) op(1, 0, 4'(i), '0, "R8");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule